// File: doc/BRIEF.md
# Load/Store Five-Stage Pipeline Core

This block is an in-order processor core split into fetch, decode, execute, memory and writeback stages. It runs programs built from three byte-encoded instructions on 64-bit data: a load that copies eight bytes from memory into a register, a store that copies a register into eight bytes of memory, and halt. It has fifteen general registers. Register code 0xF names no register.

Instruction bytes arrive on a ten-byte fetch window. Data traffic uses a separate word port. Both ports look into one byte-addressed memory held outside the core, and both read paths are combinational. The register file is read in decode. Values still in flight are forwarded into decode from the memory stage and from the writeback stage. When a load is followed directly by an instruction that reads its destination, a hazard unit holds fetch and decode for one cycle and sends a bubble into execute. Loaded values are written into the register file only from writeback.

The core reports that it has halted and how many cycles the program took. Reset is asynchronous and active low. Its release is synchronised inside the core.

Top module: `lsp_core`

## Requirements
- R1: The first byte of an instruction selects the operation by its high nibble: 0x0 is halt (1 byte), 0x4 is store and 0x5 is load (both 10 bytes). Any other value acts as a one-byte no-op. The second byte holds rA in bits 7:4 and rB in bits 3:0. Bytes 2 to 9 hold a little-endian 64-bit displacement. The PC steps by the instruction length and stays on a halt.
- R2: Register code 0xF reads as 0, and a load into it changes no register. This applies both to a store's data register and to the base register of either access.
- R3: The address of a load or store is the value of rB plus the displacement. Memory is accessed as eight bytes, little-endian, at that address.
- R4: A load's result reaches any later instruction that reads that register. When two loads in flight target the same register, the younger one's value wins. The register file is written only by a load in writeback.
- R5: If the instruction in decode reads a register (rA of a store, or rB of a load or store) that a load in execute will write, fetch and decode hold for exactly one cycle and execute receives a bubble.
- R6: A program of N loads and stores followed by halt, with no hazard of R5, reports N+5 cycles. Each stall of R5 adds exactly one cycle. Three independent loads and a halt report 8.
- R7: `halted` rises on the clock edge that retires the halt in writeback. From then on the core writes neither memory nor registers, and `cycles` stays constant.
- R8: While reset is asserted, and until its synchronised release, the PC is 0, every pipeline stage holds a bubble, all registers are 0, `cycles` is 0, `halted` is 0 and no store is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 64 | Address of the byte at the start of the fetch window (the PC) |
| imem_bytes | input | 80 | Ten instruction bytes starting at imem_addr; byte k is in bits 8k+7:8k |
| dmem_addr | output | 64 | Byte address of the data access in the memory stage |
| dmem_we | output | 1 | Store strobe; the eight bytes are written at the clock edge |
| dmem_wdata | output | 64 | Store data, little-endian |
| dmem_rdata | input | 64 | Eight bytes read at dmem_addr, little-endian, same cycle |
| halted | output | 1 | The halt has retired and the core is frozen |
| cycles | output | CNT_W | Cycles counted from reset release up to and including halt retirement |

## Verification
The assertions assume that memory answers the fetch window and the data read in the same cycle, and that every access lands inside the memory that is modelled. The bench meets this by computing addresses modulo a 2 KiB array. Random programs use only 8-byte-aligned bases and displacements, and all stored values are multiples of 8 below 256, so every computed address stays inside the data region and no program overwrites its own code. The expected stall count and the expected final memory image come from a sequential reference model run over the same bytes.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned RID_W    = 4;
  localparam int unsigned ILEN_MAX = 10;
  localparam int unsigned IBYTES_W = ILEN_MAX * 8;

  typedef logic [RID_W-1:0] rid_t;
  typedef logic [XLEN-1:0]  word_t;

  localparam rid_t REG_NONE = 4'hF;

  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5
  } op_e;

  typedef struct packed {
    op_e   op;
    rid_t  ra;
    rid_t  rb;
    word_t disp;
  } dreg_t;

  typedef struct packed {
    op_e   op;
    word_t val_a;
    word_t val_b;
    word_t disp;
    rid_t  dst;
  } ereg_t;

  typedef struct packed {
    op_e   op;
    word_t val_a;
    word_t addr;
    rid_t  dst;
  } mreg_t;

  typedef struct packed {
    op_e   op;
    word_t val_m;
    rid_t  dst;
  } wreg_t;
endpackage

// File: rtl/lsp_fetch.sv
module lsp_fetch
  import lsp_pkg::*;
(
  input  word_t                 pc,
  input  logic [IBYTES_W-1:0]   ibytes,
  output dreg_t                 inst,
  output word_t                 pc_next
);
  localparam word_t LEN_MEM = word_t'(ILEN_MAX);
  localparam word_t LEN_ONE = word_t'(1);

  always_comb begin
    inst.ra   = ibytes[15:12];
    inst.rb   = ibytes[11:8];
    inst.disp = ibytes[IBYTES_W-1:16];
    case (ibytes[7:4])
      4'h0:    inst.op = OP_HALT;
      4'h4:    inst.op = OP_STORE;
      4'h5:    inst.op = OP_LOAD;
      default: inst.op = OP_NOP;
    endcase
    case (inst.op)
      OP_HALT:           pc_next = pc;
      OP_LOAD, OP_STORE: pc_next = pc + LEN_MEM;
      default:           pc_next = pc + LEN_ONE;
    endcase
  end
endmodule

// File: rtl/lsp_regfile.sv
module lsp_regfile
  import lsp_pkg::*;
#(
  parameter int unsigned NREG   = 15,
  parameter int unsigned NREAD  = 2
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  rid_t [NREAD-1:0]       rd_sel,
  output word_t [NREAD-1:0]      rd_val,
  input  logic                   wr_en,
  input  rid_t                   wr_sel,
  input  word_t                  wr_val
);
  word_t regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_sel == rid_t'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs[i] <= '0;
      else if (ent_en) regs[i] <= wr_val;
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rd
    always_comb begin
      if (32'(rd_sel[p]) < NREG) rd_val[p] = regs[rd_sel[p]];
      else                       rd_val[p] = '0;
    end
  end
endmodule

// File: rtl/lsp_hazard.sv
module lsp_hazard
  import lsp_pkg::*;
#(
  parameter int unsigned NSRC = 2
)(
  input  rid_t  [NSRC-1:0] src,
  input  word_t [NSRC-1:0] rf_val,
  input  op_e              e_op,
  input  rid_t             e_dst,
  input  op_e              m_op,
  input  rid_t             m_dst,
  input  word_t            m_val,
  input  op_e              w_op,
  input  rid_t             w_dst,
  input  word_t            w_val,
  output word_t [NSRC-1:0] fwd_val,
  output logic             load_use
);
  logic [NSRC-1:0] hit_e;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_comb begin
      if (src[s] == REG_NONE)                       fwd_val[s] = '0;
      else if (m_op == OP_LOAD && m_dst == src[s])  fwd_val[s] = m_val;
      else if (w_op == OP_LOAD && w_dst == src[s])  fwd_val[s] = w_val;
      else                                          fwd_val[s] = rf_val[s];
    end
    assign hit_e[s] = (src[s] != REG_NONE) && (e_dst == src[s]);
  end

  assign load_use = (e_op == OP_LOAD) && (e_dst != REG_NONE) && (|hit_e);
endmodule

// File: rtl/lsp_core.sv
module lsp_core
  import lsp_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NREG        = 15
)(
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [63:0]             imem_addr,
  input  logic [IBYTES_W-1:0]     imem_bytes,
  output logic [63:0]             dmem_addr,
  output logic                    dmem_we,
  output logic [63:0]             dmem_wdata,
  input  logic [63:0]             dmem_rdata,
  output logic                    halted,
  output logic [CNT_W-1:0]        cycles
);
  localparam dreg_t D_BUB = '{op: OP_NOP, ra: REG_NONE, rb: REG_NONE, disp: '0};
  localparam ereg_t E_BUB = '{op: OP_NOP, val_a: '0, val_b: '0, disp: '0, dst: REG_NONE};
  localparam mreg_t M_BUB = '{op: OP_NOP, val_a: '0, addr: '0, dst: REG_NONE};
  localparam wreg_t W_BUB = '{op: OP_NOP, val_m: '0, dst: REG_NONE};

  // reset release synchroniser
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = sync_q[SYNC_STAGES-1];

  word_t pc_q, pc_n;
  dreg_t d_q, d_n;
  ereg_t e_q, e_n;
  mreg_t m_q, m_n;
  wreg_t w_q, w_n;
  logic  halt_q;
  logic [CNT_W-1:0] cnt_q;

  logic  run, load_use, fd_en;
  rid_t  [1:0] d_src;
  word_t [1:0] rf_rd, d_val;
  rid_t  d_dst;
  word_t m_valm;
  logic  rf_we;

  assign run   = (w_q.op != OP_HALT);
  assign fd_en = run && !load_use;

  // fetch
  lsp_fetch u_fetch (
    .pc      (pc_q),
    .ibytes  (imem_bytes),
    .inst    (d_n),
    .pc_next (pc_n)
  );
  assign imem_addr = pc_q;

  // decode
  always_comb begin
    d_src[0] = (d_q.op == OP_STORE) ? d_q.ra : REG_NONE;
    d_src[1] = (d_q.op == OP_STORE || d_q.op == OP_LOAD) ? d_q.rb : REG_NONE;
    d_dst    = (d_q.op == OP_LOAD) ? d_q.ra : REG_NONE;
  end

  lsp_regfile #(.NREG(NREG), .NREAD(2)) u_rf (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .rd_sel (d_src),
    .rd_val (rf_rd),
    .wr_en  (rf_we),
    .wr_sel (w_q.dst),
    .wr_val (w_q.val_m)
  );

  lsp_hazard #(.NSRC(2)) u_haz (
    .src      (d_src),
    .rf_val   (rf_rd),
    .e_op     (e_q.op),
    .e_dst    (e_q.dst),
    .m_op     (m_q.op),
    .m_dst    (m_q.dst),
    .m_val    (m_valm),
    .w_op     (w_q.op),
    .w_dst    (w_q.dst),
    .w_val    (w_q.val_m),
    .fwd_val  (d_val),
    .load_use (load_use)
  );

  always_comb begin
    e_n       = E_BUB;
    e_n.op    = d_q.op;
    e_n.val_a = d_val[0];
    e_n.val_b = d_val[1];
    e_n.disp  = d_q.disp;
    e_n.dst   = d_dst;
  end

  // execute
  always_comb begin
    m_n       = M_BUB;
    m_n.op    = e_q.op;
    m_n.val_a = e_q.val_a;
    m_n.addr  = e_q.val_b + e_q.disp;
    m_n.dst   = e_q.dst;
  end

  // memory
  assign dmem_addr  = m_q.addr;
  assign dmem_wdata = m_q.val_a;
  assign dmem_we    = run && (m_q.op == OP_STORE);
  assign m_valm     = (m_q.op == OP_LOAD) ? dmem_rdata : '0;

  always_comb begin
    w_n       = W_BUB;
    w_n.op    = m_q.op;
    w_n.val_m = m_valm;
    w_n.dst   = m_q.dst;
  end

  // writeback
  assign rf_we = (w_q.op == OP_LOAD) && (w_q.dst != REG_NONE);

  // pipeline registers with explicit enables
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
      d_q  <= D_BUB;
    end else if (fd_en) begin
      pc_q <= pc_n;
      d_q  <= d_n;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   e_q <= E_BUB;
    else if (run)      e_q <= load_use ? E_BUB : e_n;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      m_q <= M_BUB;
      w_q <= W_BUB;
    end else if (run) begin
      m_q <= m_n;
      w_q <= w_n;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      halt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!halt_q) begin
      halt_q <= !run;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign halted = halt_q;
  assign cycles = cnt_q;

  // R5: a hazard leaves a bubble in execute and holds fetch and decode
  a_r5_bubble_after_hazard: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_use && run) |=> (e_q.op == OP_NOP && e_q.dst == REG_NONE));
  a_r5_front_held: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_use && run) |=> ($stable(pc_q) && $stable(d_q)));
  // R3: store address follows from the execute operands one cycle earlier
  a_r3_store_address: assert property (@(posedge clk) disable iff (!core_rst_n)
    (run && e_q.op == OP_STORE) |=> (dmem_addr == $past(e_q.val_b + e_q.disp)));
  // R7: no memory write once halted, counter and flag frozen
  a_r7_no_store_when_halted: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |-> !dmem_we);
  a_r7_counter_frozen: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> (halted && $stable(cycles)));
  // R7: halted rises only after a halt sat in writeback
  a_r7_halt_from_wb: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(halted) |-> $past(w_q.op == OP_HALT));
  // R4: register file written only by a load in writeback
  a_r4_write_only_load: assert property (@(posedge clk) disable iff (!core_rst_n)
    rf_we |-> (w_q.op == OP_LOAD && !halted));
endmodule

// File: tb/lsp_core_test.sv
`timescale 1ns/1ps
module lsp_core_test;
  localparam int MEM_SZ = 2048;
  localparam int MAXI   = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] imem_addr;
  logic [79:0] imem_bytes;
  logic [63:0] dmem_addr;
  logic        dmem_we;
  logic [63:0] dmem_wdata;
  logic [63:0] dmem_rdata;
  logic        halted;
  logic [31:0] cycles;

  always #10 clk = ~clk;

  lsp_core uut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_bytes(imem_bytes),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .halted(halted), .cycles(cycles)
  );

  logic [7:0] mem  [MEM_SZ];
  logic [7:0] rmem [MEM_SZ];

  function automatic int ix(logic [63:0] a);
    return int'(a[10:0]);
  endfunction

  always_comb begin
    for (int k = 0; k < 10; k++) imem_bytes[8*k +: 8] = mem[ix(imem_addr + 64'(k))];
    for (int k = 0; k < 8; k++)  dmem_rdata[8*k +: 8] = mem[ix(dmem_addr + 64'(k))];
  end

  int late_writes = 0;
  always @(posedge clk) begin
    if (dmem_we) begin
      if (halted) late_writes++;
      for (int k = 0; k < 8; k++) mem[ix(dmem_addr + 64'(k))] <= dmem_wdata[8*k +: 8];
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // program under construction
  int     p_op[MAXI], p_ra[MAXI], p_rb[MAXI];
  longint p_disp[MAXI];
  int     n_ins;

  task automatic clear_mem();
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'h00;
    n_ins = 0;
  endtask

  task automatic put_word(int a, longint v);
    for (int k = 0; k < 8; k++) mem[(a + k) % MEM_SZ] = v[8*k +: 8];
  endtask

  task automatic add(int op, int ra, int rb, longint disp);
    p_op[n_ins] = op; p_ra[n_ins] = ra; p_rb[n_ins] = rb; p_disp[n_ins] = disp;
    n_ins++;
  endtask

  function automatic longint rd8(logic [63:0] a);
    longint v = 0;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = rmem[ix(a + 64'(k))];
    return v;
  endfunction

  // writes program bytes, runs reference model, returns expected cycle count
  task automatic build(output int exp_cyc);
    int pc = 0, stalls = 0;
    longint regs[16];
    for (int i = 0; i < n_ins; i++) begin
      mem[pc] = (p_op[i] == 1) ? 8'h50 : 8'h40;
      mem[pc+1] = {p_ra[i][3:0], p_rb[i][3:0]};
      for (int k = 0; k < 8; k++) mem[pc+2+k] = p_disp[i][8*k +: 8];
      pc += 10;
    end
    mem[pc] = 8'h00;
    for (int i = 0; i < MEM_SZ; i++) rmem[i] = mem[i];
    for (int r = 0; r < 16; r++) regs[r] = 0;
    for (int i = 0; i < n_ins; i++) begin
      logic [63:0] a;
      a = regs[p_rb[i]] + p_disp[i];
      if (p_op[i] == 1) begin
        if (p_ra[i] != 15) regs[p_ra[i]] = rd8(a);
      end else begin
        for (int k = 0; k < 8; k++) rmem[ix(a + 64'(k))] = regs[p_ra[i]][8*k +: 8];
      end
      if (i + 1 < n_ins && p_op[i] == 1 && p_ra[i] != 15) begin
        if (p_rb[i+1] == p_ra[i] || (p_op[i+1] == 0 && p_ra[i+1] == p_ra[i])) stalls++;
      end
    end
    exp_cyc = n_ins + 5 + stalls;
  endtask

  task automatic run_prog(string name, bit check_cyc);
    int exp_cyc, t, bad;
    longint frz;
    build(exp_cyc);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(halted == 1'b0 && cycles == 0 && dmem_we == 1'b0, "R8", {name, " reset outputs"},
        {halted, cycles}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(imem_addr == 0, "R8", {name, " pc after reset"}, imem_addr, 0);
    t = 0;
    while (!halted && t < 400) begin @(negedge clk); t++; end
    chk(halted, "R7", {name, " halt reached"}, halted, 1);
    if (check_cyc) chk(cycles == exp_cyc, "R6", {name, " cycle count"}, cycles, exp_cyc);
    frz = cycles;
    repeat (5) @(negedge clk);
    chk(halted && cycles == frz && late_writes == 0, "R7", {name, " frozen after halt"},
        cycles, frz);
    bad = -1;
    for (int i = MEM_SZ - 1; i >= 0; i--) if (mem[i] !== rmem[i]) bad = i;
    if (bad >= 0) chk(0, "R3", {name, " memory image"}, mem[bad], rmem[bad]);
    else          chk(1, "R3", {name, " memory image"}, 0, 0);
  endtask

  function automatic int pick_reg();
    int r = int'($urandom % 5);
    return (r == 4) ? 15 : r;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "R6", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5eed));
    rst_n = 1'b0;

    // R6: three independent loads then halt take 8 cycles
    clear_mem(); put_word(256, 64'h200); put_word(512, 64'hfe);
    add(1, 0, 8, 256); add(1, 1, 8, 512); add(1, 2, 8, 254);
    run_prog("R6 three loads", 1);
    chk(cycles == 8, "R6", "independent loads exact", cycles, 8);

    // R1 R3: same loads with results written back to memory
    clear_mem(); put_word(256, 64'h200); put_word(512, 64'hfe);
    add(1, 0, 8, 256); add(1, 1, 8, 512); add(1, 2, 8, 254);
    add(0, 0, 8, 768); add(0, 1, 8, 776); add(0, 2, 8, 784);
    run_prog("R1 load store", 1);

    // R5: chained loads stall twice
    clear_mem(); put_word(256, 64'h200); put_word(512, 64'hfe);
    add(1, 0, 8, 256); add(1, 1, 0, 0); add(1, 2, 1, 0);
    run_prog("R5 chain", 1);
    chk(cycles == 10, "R5", "two stalls cost two cycles", cycles, 10);

    // R5: load feeding a store's data and base, reading own code bytes
    clear_mem();
    add(1, 0, 8, 1); add(0, 0, 0, 160); add(1, 2, 0, 158); add(0, 2, 8, 768);
    run_prog("R5 store after load", 1);

    // R2: register code 0xF ignored as target, reads zero
    clear_mem(); put_word(256, 64'h1234); put_word(768, 64'h5555_aaaa);
    add(1, 15, 8, 256); add(0, 15, 8, 768); add(1, 0, 15, 256); add(0, 0, 8, 776);
    run_prog("R2 none register", 1);

    // R4: two loads to one register, younger value wins
    clear_mem(); put_word(256, 64'h111); put_word(512, 64'h222);
    add(1, 0, 8, 256); add(1, 0, 8, 512); add(0, 0, 8, 800);
    run_prog("R4 newest wins", 1);

    // R4 R5 R6: random programs
    for (int p = 0; p < 12; p++) begin
      int n;
      clear_mem();
      for (int w = 512; w < MEM_SZ; w += 8) put_word(w, longint'(($urandom % 32) * 8));
      n = 4 + int'($urandom % 9);
      for (int i = 0; i < n; i++)
        add(($urandom % 10) < 6 ? 1 : 0, pick_reg(), pick_reg(),
            longint'(512 + 8 * ($urandom % 128)));
      run_prog("R4 random", 1);
    end

    finish_run();
  end
endmodule